// File: doc/BRIEF.md
# Semaphore Release Interrupt Unit

This block turns semaphore release events into processor interrupts. A vector of one-cycle pulses, one bit per semaphore, reports which semaphores became free in the current cycle. Each processor has its own interrupt line. For each line the block keeps four per-semaphore bit vectors: an enable mask, a raw pending status, a masked pending status and a write-one-to-clear command. It drives one registered interrupt output per processor.

Software reaches the registers over a simple 32-bit register bus. Each access is a single cycle. Read data is registered and appears one clock after the read is sampled. A processor that failed to take a semaphore can then wait for its release interrupt instead of polling.

The semaphore storage and any bus master identity checks sit outside this block. A bulk release by key elsewhere simply arrives here as several pulse bits set in the same cycle.

Top module: `sem_release_irq`

## Requirements
- R1: Line k (k = 0 .. NLINES-1) has a register window at byte address BASE + STRIDE*k, with BASE = 0x100 and STRIDE = 0x10 by default. Inside the window, offset +0x0 is the enable mask, +0x4 the clear command, +0x8 the raw status and +0xC the masked status. Bit i of each register belongs to semaphore i. The read data of a read sampled at a clock edge appears on `bus_rdata` after that edge. A read of any unmapped address returns 0.
- R2: A release pulse on bit i sets raw status bit i of every line, whether or not that line enables semaphore i.
- R3: Masked status bit i of a line is set by a release only while that line's enable bit i is already 1. Clearing an enable bit clears the matching masked bit, so a masked bit never reads 1 while its enable bit is 0.
- R4: Writing 1 to bit i of a line's clear register clears that line's raw and masked status bit i. Writing 0 changes nothing, and the clear register always reads 0.
- R5: A line's `irq_o` bit is 1 exactly while at least one masked status bit of that line is 1. It changes on the same clock edge as the masked status, and it falls only after every masked bit of the line is clear.
- R6: Several release bits asserted in the same cycle set all of their status bits together.
- R7: When a release pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: After a synchronous active-high reset, all enable, raw and masked status bits are 0, `irq_o` is 0 and `bus_rdata` is 0.
- R9: Writes to the raw and masked status addresses have no effect.
- R10: The lines are independent. An enable or clear write to one line leaves the other line's registers and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rel_i | input | NSEM | One-cycle semaphore release pulses, bit i for semaphore i |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | NLINES | One interrupt per processor line |

## Verification
Suppose a raw or masked bit is wrongly held, for example a stale masked bit left behind after a disable or a clear. It shows on `irq_o` at the very edge that should have dropped it. A status read issued after that edge shows it one clock later. A release that is lost, or that reaches the wrong line, shows the same way: the raw or masked read-back differs from the expected vector at the first read after the pulse. Because reads do not change state, the bench can compare all eight registers after every stimulus cycle.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  // Register slot within one processor line window (byte offset / 4).
  typedef enum logic [1:0] {
    REG_EN  = 2'd0,
    REG_CLR = 2'd1,
    REG_RAW = 2'd2,
    REG_MSK = 2'd3
  } sirq_reg_e;
endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h100,
  parameter int STRIDE = 'h10,
  parameter int NLINES = 2
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NLINES-1:0] line_hit,
  output sirq_reg_e         reg_sel,
  output logic [NLINES-1:0] en_we,
  output logic [NLINES-1:0] clr_we
);
  localparam int                OFS_W     = $clog2(STRIDE);
  localparam logic [ADDR_W-1:0] BASE_A    = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] SPAN_A    = ADDR_W'(NLINES * STRIDE);
  localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'(STRIDE - 1);
  localparam logic [ADDR_W-1:0] SLOT_SPAN = ADDR_W'(16);

  logic [ADDR_W-1:0] rel_addr;
  logic [ADDR_W-1:0] ofs;
  logic              slot_ok;

  always_comb begin
    rel_addr = bus_addr - BASE_A;
    ofs      = rel_addr & OFS_MASK;
    slot_ok  = (bus_addr >= BASE_A) && (rel_addr < SPAN_A) &&
               (ofs < SLOT_SPAN) && (ofs[1:0] == 2'b00);
    reg_sel  = sirq_reg_e'(ofs[3:2]);
  end

  for (genvar k = 0; k < NLINES; k++) begin : g_hit
    always_comb begin
      line_hit[k] = slot_ok && ((rel_addr >> OFS_W) == ADDR_W'(k));
      en_we[k]    = bus_sel && bus_wr && line_hit[k] && (reg_sel == REG_EN);
      clr_we[k]   = bus_sel && bus_wr && line_hit[k] && (reg_sel == REG_CLR);
    end
  end

  // R1: an address selects at most one line window
  always_comb begin
    p_single_line_r1: assert ($onehot0(line_hit));
  end
endmodule

// File: rtl/sirq_line.sv
module sirq_line #(
  parameter int NSEM = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSEM-1:0] rel_i,
  input  logic            en_we,
  input  logic            clr_we,
  input  logic [NSEM-1:0] wdata,
  output logic [NSEM-1:0] en_q,
  output logic [NSEM-1:0] raw_q,
  output logic [NSEM-1:0] msk_q,
  output logic            irq_q
);
  logic [NSEM-1:0] clr_vec;
  logic [NSEM-1:0] en_nxt;
  logic [NSEM-1:0] raw_nxt;
  logic [NSEM-1:0] msk_nxt;

  for (genvar i = 0; i < NSEM; i++) begin : g_bit
    always_comb begin
      clr_vec[i] = clr_we & wdata[i];
      en_nxt[i]  = en_we ? wdata[i] : en_q[i];
      // a release in the same cycle overrides the clear
      raw_nxt[i] = (raw_q[i] & ~clr_vec[i]) | rel_i[i];
      msk_nxt[i] = ((msk_q[i] & ~clr_vec[i]) | (rel_i[i] & en_q[i])) & en_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      raw_q <= '0;
      msk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      raw_q <= raw_nxt;
      msk_q <= msk_nxt;
      irq_q <= |msk_nxt;
    end
  end

  // R2, R6: every pulsed bit is pending on the next cycle
  p_release_sets_raw_r2: assert property (@(posedge clk) disable iff (rst)
    (|rel_i) |=> ((raw_q & $past(rel_i)) == $past(rel_i)));

  // R3: masked pending is a subset of raw pending
  p_msk_within_raw_r3: assert property (@(posedge clk) disable iff (rst)
    ((msk_q & ~raw_q) == '0));

  // R3: masked pending never shows for a disabled semaphore
  p_msk_needs_enable_r3: assert property (@(posedge clk) disable iff (rst)
    ((msk_q & ~en_q) == '0));

  // R4: a clear with no concurrent release empties the raw bits
  p_clear_empties_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_we && (rel_i == '0)) |=> ((raw_q & $past(wdata)) == '0));

  // R5: the line only falls after a clear or an enable write
  p_irq_fall_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_q) |-> $past(clr_we || en_we));

  // R7: release wins over a clear aimed at the same bit
  p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_we && ((rel_i & wdata) != '0)) |=>
      ((raw_q & $past(rel_i & wdata)) == $past(rel_i & wdata)));
endmodule

// File: rtl/sirq_rdmux.sv
module sirq_rdmux
  import sirq_pkg::*;
#(
  parameter int NSEM   = 32,
  parameter int NLINES = 2,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  logic [NLINES-1:0]           line_hit,
  input  sirq_reg_e                   reg_sel,
  input  logic [NLINES-1:0][NSEM-1:0] en_all,
  input  logic [NLINES-1:0][NSEM-1:0] raw_all,
  input  logic [NLINES-1:0][NSEM-1:0] msk_all,
  output logic [DATA_W-1:0]           rdata_q
);
  logic [NSEM-1:0] sel_v;

  always_comb begin
    sel_v = '0;
    for (int k = 0; k < NLINES; k++) begin
      if (line_hit[k]) begin
        case (reg_sel)
          REG_EN:  sel_v = sel_v | en_all[k];
          REG_RAW: sel_v = sel_v | raw_all[k];
          REG_MSK: sel_v = sel_v | msk_all[k];
          default: sel_v = sel_v;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= DATA_W'(sel_v);
    end
  end

  // R4: the clear command slot always reads as zero
  p_clear_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (|line_hit) && (reg_sel == REG_CLR)) |=> (rdata_q == '0));

  // R1: unmapped reads return zero
  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (line_hit == '0)) |=> (rdata_q == '0));
endmodule

// File: rtl/sem_release_irq.sv
module sem_release_irq
  import sirq_pkg::*;
#(
  parameter int NSEM   = 32,
  parameter int NLINES = 2,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BASE   = 'h100,
  parameter int STRIDE = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSEM-1:0]   rel_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NLINES-1:0] irq_o
);
  logic [NLINES-1:0]           line_hit;
  sirq_reg_e                   reg_sel;
  logic [NLINES-1:0]           en_we;
  logic [NLINES-1:0]           clr_we;
  logic [NLINES-1:0][NSEM-1:0] en_all;
  logic [NLINES-1:0][NSEM-1:0] raw_all;
  logic [NLINES-1:0][NSEM-1:0] msk_all;
  logic [NSEM-1:0]             wdata_sem;
  logic                        rd_en;

  always_comb begin
    wdata_sem = bus_wdata[NSEM-1:0];
    rd_en     = bus_sel & ~bus_wr;
  end

  sirq_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE), .NLINES(NLINES)
  ) u_decode (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .line_hit(line_hit),
    .reg_sel (reg_sel),
    .en_we   (en_we),
    .clr_we  (clr_we)
  );

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    sirq_line #(.NSEM(NSEM)) u_line (
      .clk   (clk),
      .rst   (rst),
      .rel_i (rel_i),
      .en_we (en_we[k]),
      .clr_we(clr_we[k]),
      .wdata (wdata_sem),
      .en_q  (en_all[k]),
      .raw_q (raw_all[k]),
      .msk_q (msk_all[k]),
      .irq_q (irq_o[k])
    );
  end

  sirq_rdmux #(
    .NSEM(NSEM), .NLINES(NLINES), .DATA_W(DATA_W)
  ) u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .line_hit(line_hit),
    .reg_sel (reg_sel),
    .en_all  (en_all),
    .raw_all (raw_all),
    .msk_all (msk_all),
    .rdata_q (bus_rdata)
  );
endmodule

// File: tb/sem_release_irq_bench.sv
`timescale 1ns/1ps
module sem_release_irq_bench;
  localparam int NSEM = 32;
  localparam int NL   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rel_i = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] m_en  [NL];
  logic [31:0] m_raw [NL];
  logic [31:0] m_msk [NL];

  always #10 clk = ~clk;

  sem_release_irq u_sem_release_irq (
    .clk(clk), .rst(rst), .rel_i(rel_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [11:0] reg_addr(input int line, input int slot);
    return 12'(32'h100 + 32'h10 * line + 4 * slot);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One stimulus cycle: optional release pulses and optional bus write.
  task automatic cycle_op(input logic [31:0] rel, input logic wr,
                          input logic [11:0] addr, input logic [31:0] wd);
    logic [31:0] clr;
    logic [31:0] en_new;
    rel_i = rel; bus_sel = wr; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    rel_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    for (int k = 0; k < NL; k++) begin
      clr    = (wr && addr == reg_addr(k, 1)) ? wd : 32'h0;
      en_new = (wr && addr == reg_addr(k, 0)) ? wd : m_en[k];
      m_raw[k] = (m_raw[k] & ~clr) | rel;
      m_msk[k] = ((m_msk[k] & ~clr) | (rel & m_en[k])) & en_new;
      m_en[k]  = en_new;
    end
  endtask

  task automatic bus_read(input logic [11:0] addr, output logic [31:0] data);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
    @(posedge clk);
    @(negedge clk);
    data = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    for (int k = 0; k < NL; k++) begin
      check(req, $sformatf("irq line %0d", k), 32'(irq_o[k]), 32'(|m_msk[k]));
      bus_read(reg_addr(k, 0), d); check(req, $sformatf("enable line %0d", k), d, m_en[k]);
      bus_read(reg_addr(k, 1), d); check("R4", $sformatf("clear reads 0 line %0d", k), d, 32'h0);
      bus_read(reg_addr(k, 2), d); check(req, $sformatf("raw line %0d", k), d, m_raw[k]);
      bus_read(reg_addr(k, 3), d); check(req, $sformatf("masked line %0d", k), d, m_msk[k]);
    end
  endtask

  task automatic wipe();
    cycle_op('0, 1'b1, reg_addr(0, 0), 32'h0);
    cycle_op('0, 1'b1, reg_addr(1, 0), 32'h0);
    cycle_op('0, 1'b1, reg_addr(0, 1), 32'hFFFF_FFFF);
    cycle_op('0, 1'b1, reg_addr(1, 1), 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R8", "irq after reset", 32'(irq_o), 32'h0);
    check("R8", "rdata after reset", bus_rdata, 32'h0);
    check_all("R8");
    bus_read(12'h140, d);
    check("R1", "unmapped read", d, 32'h0);
    bus_read(12'h102, d);
    check("R1", "misaligned read", d, 32'h0);
  endtask

  task automatic t_raw_without_enable();
    cycle_op(32'h0000_0008, 1'b0, '0, '0);
    check("R2", "irq stays low", 32'(irq_o), 32'h0);
    check_all("R2");
    wipe();
  endtask

  task automatic t_enable_and_mask();
    cycle_op('0, 1'b1, reg_addr(0, 0), 32'h0000_0020);
    cycle_op(32'h0000_0060, 1'b0, '0, '0);
    check("R3", "line0 irq", 32'(irq_o), 32'h1);
    check_all("R3");
    // release while enable write of same bit lands: old enable used
    cycle_op(32'h0000_0100, 1'b1, reg_addr(1, 0), 32'h0000_0100);
    check_all("R3");
    cycle_op('0, 1'b1, reg_addr(0, 0), 32'h0);
    check("R3", "disable drops irq", 32'(irq_o), 32'h0);
    check_all("R3");
    wipe();
  endtask

  task automatic t_clear_rules();
    cycle_op('0, 1'b1, reg_addr(0, 0), 32'h0000_0006);
    cycle_op(32'h0000_0006, 1'b0, '0, '0);
    cycle_op('0, 1'b1, reg_addr(0, 1), 32'h0);
    check("R4", "zero clear keeps irq", 32'(irq_o), 32'h1);
    check_all("R4");
    cycle_op('0, 1'b1, reg_addr(0, 1), 32'h0000_0002);
    check("R5", "irq held by remaining bit", 32'(irq_o), 32'h1);
    check_all("R5");
    cycle_op('0, 1'b1, reg_addr(0, 1), 32'h0000_0004);
    check("R5", "irq drops when all clear", 32'(irq_o), 32'h0);
    check_all("R4");
    wipe();
  endtask

  task automatic t_bulk_release();
    cycle_op('0, 1'b1, reg_addr(1, 0), 32'hFFFF_0000);
    cycle_op(32'hF0F0_0001, 1'b0, '0, '0);
    check("R6", "line1 irq only", 32'(irq_o), 32'h2);
    check_all("R6");
    // clearing line 0 must not touch line 1
    cycle_op('0, 1'b1, reg_addr(0, 1), 32'hFFFF_FFFF);
    check("R10", "line1 irq unaffected", 32'(irq_o), 32'h2);
    check_all("R10");
    wipe();
  endtask

  task automatic t_set_wins();
    cycle_op('0, 1'b1, reg_addr(0, 0), 32'h0000_0200);
    cycle_op(32'h0000_0200, 1'b1, reg_addr(0, 1), 32'h0000_0200);
    check("R7", "irq kept", 32'(irq_o), 32'h1);
    check_all("R7");
    wipe();
  endtask

  task automatic t_readonly();
    cycle_op('0, 1'b1, reg_addr(0, 0), 32'h0000_0001);
    cycle_op(32'h8000_0001, 1'b0, '0, '0);
    cycle_op('0, 1'b1, reg_addr(0, 2), 32'h0);
    cycle_op('0, 1'b1, reg_addr(0, 3), 32'h0);
    check("R9", "irq after status writes", 32'(irq_o), 32'h1);
    check_all("R9");
    wipe();
  endtask

  initial begin
    for (int k = 0; k < NL; k++) begin
      m_en[k] = '0; m_raw[k] = '0; m_msk[k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_raw_without_enable();
    t_enable_and_mask();
    t_clear_rules();
    t_bulk_release();
    t_set_wins();
    t_readonly();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule